// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block brings a display controller's two-wire management bus back to a usable state after a power transition. When asked to start, it first checks whether the device was left without power. If so, it requests power and waits for the rails to settle. It then keeps the data line released (high) and pulses the clock line a fixed number of times, which forces the device's bus state machine back to idle.

After the burst it checks whether the device answers. It asks an external register-read engine to fetch the device identity word, once per millisecond, until a valid identity comes back. If the whole poll budget fails, it removes power, waits, restores power and runs the complete sequence again.

On success it pulses a completion flag. It also reports whether the device went through a power-up during the sequence, so that the caller knows the device registers must be programmed again.

The clock and data outputs are open-drain enables. A 1 releases the line and a 0 pulls it low. Timing is counted in external microsecond and millisecond tick pulses, so the block does not depend on the system clock frequency.

Top module: `busrec_seq`

## Requirements
- R1: During and directly after reset, scl_rel_o and sda_rel_o are 1, and pwr_up_o, pwr_down_o, poll_req_o, done_o and reinit_o are 0.
- R2: Each recovery burst produces exactly PULSES (default 16) low pulses on scl_rel_o, with sda_rel_o held at 1. scl_rel_o stays 1 whenever no burst is running.
- R3: Every low phase of the clock lasts HALF_US microsecond ticks, and so does every high phase between two pulses. The burst ends SETTLE_US microsecond ticks after the last rising edge.
- R4: A start accepted with was_off_i = 1 gives a one-cycle pwr_up_o pulse. The first clock fall of the burst follows PWRON_MS millisecond ticks later, or one tick more if a millisecond tick lands inside the first high phase.
- R5: After a burst, each poll is preceded by exactly one millisecond tick. poll_req_o stays high until poll_ack_i is seen. Polling stops at the first valid identity.
- R6: A returned identity word is valid only when bits [15:8] equal 0xDC. The value of bits [7:0] does not matter.
- R7: When POLL_MAX (default 50) polls in a row all fail, pwr_down_o pulses for one cycle. PWROFF_MS millisecond ticks later pwr_up_o pulses, and the R4 power-up, a new burst and a fresh poll budget follow.
- R8: done_o is a one-cycle pulse issued with the successful poll response. At that same edge reinit_o becomes 1 if the sequence included any power-up step, and 0 otherwise. reinit_o keeps that value until the next accepted start clears it.
- R9: A start_i pulse that arrives while a sequence is running has no effect. The burst pulse count, the power events, the poll sequence and the final reinit_o value all stay the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, acted on only while idle |
| was_off_i | input | 1 | Device is unpowered; sampled with an accepted start |
| us_tick_i | input | 1 | One-cycle pulse every microsecond |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| poll_ack_i | input | 1 | Read engine returns the identity word |
| poll_id_i | input | ID_W | Identity word, valid together with poll_ack_i |
| scl_rel_o | output | 1 | Clock line: 1 releases the line, 0 pulls it low |
| sda_rel_o | output | 1 | Data line: 1 releases the line, 0 pulls it low |
| pwr_up_o | output | 1 | One-cycle request to power the device |
| pwr_down_o | output | 1 | One-cycle request to remove device power |
| poll_req_o | output | 1 | Identity read request, held until acknowledged |
| done_o | output | 1 | One-cycle completion pulse |
| reinit_o | output | 1 | Device registers need to be programmed again |

## Verification
The assertions assume that both tick inputs are single-cycle pulses, and that poll_ack_i is raised only while poll_req_o is high. They also assume that a millisecond tick never falls on the same edge as the power-step expiry.

The bench drives the microsecond tick every 4 cycles and the millisecond tick every 200 cycles. Its read responder answers two cycles after it sees a request, which is far inside one millisecond period.

The phase widths are measured in ticks, not in clock cycles, so they match the counts in R3, R4, R5 and R7 exactly. The single exception is the power-up to first fall window of R4, which may contain one extra tick.

// File: rtl/busrec_pkg.sv
package busrec_pkg;

  // Sequencer level
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWR_ON,
    ST_BURST,
    ST_POLL_WAIT,
    ST_POLL_REQ,
    ST_PWR_OFF
  } seq_state_t;

  // Clock burst level
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_HIGH,
    PH_LOW,
    PH_SETTLE
  } burst_phase_t;

endpackage

// File: rtl/busrec_timer.sv
module busrec_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] limit_i,
  input  logic         tick_i,
  output logic         expired_o
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load_i) begin
      cnt <= limit_i;
    end else if (tick_i && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired_o = (cnt == '0);

  // The count only ever moves down between loads (timing of R4 / R7)
  p_no_rewind_r7: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> (cnt <= $past(cnt)));

endmodule

// File: rtl/busrec_burst.sv
module busrec_burst
  import busrec_pkg::*;
#(
  parameter int PULSES    = 16,
  parameter int HALF_US   = 5,
  parameter int SETTLE_US = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  input  logic us_tick_i,
  output logic scl_rel_o,
  output logic busy_o,
  output logic done_o
);

  localparam int UMAX = (HALF_US > SETTLE_US) ? HALF_US : SETTLE_US;
  localparam int UW   = $clog2(UMAX + 1);
  localparam int PW   = $clog2(PULSES + 1);
  localparam logic [UW-1:0] HALF_LAST   = UW'(HALF_US - 1);
  localparam logic [UW-1:0] SETTLE_LAST = UW'(SETTLE_US - 1);
  localparam logic [PW-1:0] PULSE_LAST  = PW'(PULSES - 1);

  burst_phase_t  phase;
  logic [UW-1:0] us_cnt;
  logic [PW-1:0] pulse_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      us_cnt    <= '0;
      pulse_cnt <= '0;
      scl_rel_o <= 1'b1;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (go_i) begin
            phase     <= PH_HIGH;
            us_cnt    <= '0;
            pulse_cnt <= '0;
          end
        end
        PH_HIGH: begin
          if (us_tick_i) begin
            if (us_cnt == HALF_LAST) begin
              us_cnt    <= '0;
              scl_rel_o <= 1'b0;
              phase     <= PH_LOW;
            end else begin
              us_cnt <= us_cnt + 1'b1;
            end
          end
        end
        PH_LOW: begin
          if (us_tick_i) begin
            if (us_cnt == HALF_LAST) begin
              us_cnt    <= '0;
              scl_rel_o <= 1'b1;
              pulse_cnt <= pulse_cnt + 1'b1;
              phase     <= (pulse_cnt == PULSE_LAST) ? PH_SETTLE : PH_HIGH;
            end else begin
              us_cnt <= us_cnt + 1'b1;
            end
          end
        end
        PH_SETTLE: begin
          if (us_tick_i) begin
            if (us_cnt == SETTLE_LAST) begin
              us_cnt <= '0;
              phase  <= PH_IDLE;
              done_o <= 1'b1;
            end else begin
              us_cnt <= us_cnt + 1'b1;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy_o = (phase != PH_IDLE);

  p_pulse_bound_r2: assert property (@(posedge clk) disable iff (rst)
    pulse_cnt <= PW'(PULSES));

  p_phase_bound_r3: assert property (@(posedge clk) disable iff (rst)
    us_cnt < UW'(UMAX));

  // A rising clock edge always completes a counted pulse (R2)
  p_rise_counted_r2: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $rose(scl_rel_o)) |-> (pulse_cnt != '0));

endmodule

// File: rtl/busrec_seq.sv
module busrec_seq
  import busrec_pkg::*;
#(
  parameter int          PULSES    = 16,
  parameter int          HALF_US   = 5,
  parameter int          SETTLE_US = 5,
  parameter int          POLL_MAX  = 50,
  parameter int          PWRON_MS  = 10,
  parameter int          PWROFF_MS = 100,
  parameter int          ID_W      = 16,
  parameter int          TAG_W     = 8,
  parameter logic [TAG_W-1:0] ID_TAG = 8'hDC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            was_off_i,
  input  logic            us_tick_i,
  input  logic            ms_tick_i,
  input  logic            poll_ack_i,
  input  logic [ID_W-1:0] poll_id_i,
  output logic            scl_rel_o,
  output logic            sda_rel_o,
  output logic            pwr_up_o,
  output logic            pwr_down_o,
  output logic            poll_req_o,
  output logic            done_o,
  output logic            reinit_o
);

  localparam int MS_MAX = (PWRON_MS > PWROFF_MS) ? PWRON_MS : PWROFF_MS;
  localparam int MW     = $clog2(MS_MAX + 1);
  localparam int PCW    = $clog2(POLL_MAX + 1);
  localparam logic [PCW-1:0] POLL_LAST = PCW'(POLL_MAX - 1);

  seq_state_t     state;
  logic [PCW-1:0] poll_cnt;
  logic           off_flag;
  logic           burst_go;
  logic           burst_busy;
  logic           burst_done;
  logic           tmr_load;
  logic [MW-1:0]  tmr_lim;
  logic           tmr_exp;
  logic           id_ok;

  assign id_ok     = (poll_id_i[ID_W-1 -: TAG_W] == ID_TAG);
  assign sda_rel_o = 1'b1;

  // Timer load is decided in the same cycle as the state change,
  // so the count is ready in the first cycle of the timed state.
  always_comb begin
    tmr_load = 1'b0;
    tmr_lim  = MW'(PWRON_MS);
    unique case (state)
      ST_IDLE:     tmr_load = start_i && was_off_i;
      ST_POLL_REQ: begin
        tmr_load = poll_ack_i && !id_ok && (poll_cnt == POLL_LAST);
        tmr_lim  = MW'(PWROFF_MS);
      end
      ST_PWR_OFF:  tmr_load = tmr_exp;
      default:     tmr_load = 1'b0;
    endcase
  end

  busrec_timer #(.W(MW)) i_ms_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (tmr_load),
    .limit_i   (tmr_lim),
    .tick_i    (ms_tick_i),
    .expired_o (tmr_exp)
  );

  busrec_burst #(
    .PULSES    (PULSES),
    .HALF_US   (HALF_US),
    .SETTLE_US (SETTLE_US)
  ) i_burst (
    .clk       (clk),
    .rst       (rst),
    .go_i      (burst_go),
    .us_tick_i (us_tick_i),
    .scl_rel_o (scl_rel_o),
    .busy_o    (burst_busy),
    .done_o    (burst_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      poll_cnt   <= '0;
      off_flag   <= 1'b0;
      burst_go   <= 1'b0;
      pwr_up_o   <= 1'b0;
      pwr_down_o <= 1'b0;
      poll_req_o <= 1'b0;
      done_o     <= 1'b0;
      reinit_o   <= 1'b0;
    end else begin
      burst_go   <= 1'b0;
      pwr_up_o   <= 1'b0;
      pwr_down_o <= 1'b0;
      done_o     <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_i) begin
            reinit_o <= 1'b0;
            off_flag <= was_off_i;
            if (was_off_i) begin
              pwr_up_o <= 1'b1;
              state    <= ST_PWR_ON;
            end else begin
              burst_go <= 1'b1;
              state    <= ST_BURST;
            end
          end
        end
        ST_PWR_ON: begin
          if (tmr_exp) begin
            burst_go <= 1'b1;
            state    <= ST_BURST;
          end
        end
        ST_BURST: begin
          if (burst_done) begin
            poll_cnt <= '0;
            state    <= ST_POLL_WAIT;
          end
        end
        ST_POLL_WAIT: begin
          if (ms_tick_i) begin
            poll_req_o <= 1'b1;
            state      <= ST_POLL_REQ;
          end
        end
        ST_POLL_REQ: begin
          if (poll_ack_i) begin
            poll_req_o <= 1'b0;
            if (id_ok) begin
              done_o   <= 1'b1;
              reinit_o <= off_flag;
              state    <= ST_IDLE;
            end else if (poll_cnt == POLL_LAST) begin
              pwr_down_o <= 1'b1;
              off_flag   <= 1'b1;
              state      <= ST_PWR_OFF;
            end else begin
              poll_cnt <= poll_cnt + 1'b1;
              state    <= ST_POLL_WAIT;
            end
          end
        end
        ST_PWR_OFF: begin
          if (tmr_exp) begin
            pwr_up_o <= 1'b1;
            state    <= ST_PWR_ON;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (poll_req_o && !poll_ack_i) |=> poll_req_o);

  p_poll_budget_r5: assert property (@(posedge clk) disable iff (rst)
    poll_cnt < PCW'(POLL_MAX));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_scl_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (state != ST_BURST && !burst_busy) |-> scl_rel_o);

  p_down_after_poll_r7: assert property (@(posedge clk) disable iff (rst)
    pwr_down_o |-> $past(poll_ack_i));

  p_power_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(pwr_up_o && pwr_down_o));

endmodule

// File: tb/test_busrec_seq.sv
module test_busrec_seq;

  localparam int PULSES  = 16;
  localparam int HALF    = 5;
  localparam int POLLMAX = 50;
  localparam int ONMS    = 10;
  localparam int OFFMS   = 100;
  localparam int USP     = 4;
  localparam int MSP     = 200;

  localparam int EV_FALL  = 1;
  localparam int EV_RISE  = 2;
  localparam int EV_UP    = 3;
  localparam int EV_DOWN  = 4;
  localparam int EV_POLL  = 5;
  localparam int EV_DONE0 = 6;
  localparam int EV_DONE1 = 7;

  logic        clk = 1'b0;
  logic        rst;
  logic        start_i, was_off_i, us_tick_i, ms_tick_i, poll_ack_i;
  logic [15:0] poll_id_i;
  logic        scl_rel_o, sda_rel_o, pwr_up_o, pwr_down_o;
  logic        poll_req_o, done_o, reinit_o;

  always #10 clk = ~clk;

  busrec_seq i_busrec_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .was_off_i  (was_off_i),
    .us_tick_i  (us_tick_i),
    .ms_tick_i  (ms_tick_i),
    .poll_ack_i (poll_ack_i),
    .poll_id_i  (poll_id_i),
    .scl_rel_o  (scl_rel_o),
    .sda_rel_o  (sda_rel_o),
    .pwr_up_o   (pwr_up_o),
    .pwr_down_o (pwr_down_o),
    .poll_req_o (poll_req_o),
    .done_o     (done_o),
    .reinit_o   (reinit_o)
  );

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  int fail_left = 0;
  int done_cnt = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic sb_pop(input int code, input string tag);
    int e;
    if (exp_q.size() == 0) begin
      chk(1'b0, {tag, " unexpected event"}, code, 0);
    end else begin
      e = exp_q.pop_front();
      chk(e == code, tag, code, e);
    end
  endtask

  // Tick generator, driven just after the rising edge
  initial begin : ticks
    int cyc;
    cyc = 0;
    us_tick_i = 1'b0;
    ms_tick_i = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      us_tick_i = (cyc % USP) == 0;
      ms_tick_i = (cyc % MSP) == 0;
    end
  end

  // Read engine model
  initial begin : responder
    logic [15:0] bad [5];
    logic [15:0] good[2];
    int bp, gp;
    bad[0] = 16'hDB12; bad[1] = 16'h00DC; bad[2] = 16'h0000;
    bad[3] = 16'hFCDC; bad[4] = 16'hDD00;
    good[0] = 16'hDC00; good[1] = 16'hDCFF;
    bp = 0; gp = 0;
    poll_ack_i = 1'b0;
    poll_id_i  = 16'h0;
    forever begin
      @(negedge clk);
      if (!rst && poll_req_o) begin
        repeat (2) @(posedge clk);
        #1;
        poll_ack_i = 1'b1;
        if (fail_left > 0) begin
          poll_id_i = bad[bp % 5];
          bp++;
          fail_left--;
        end else begin
          poll_id_i = good[gp % 2];
          gp++;
        end
        @(posedge clk);
        #1;
        poll_ack_i = 1'b0;
        poll_id_i  = 16'h0;
      end
    end
  end

  // Monitor: pops expected events and measures phase widths in ticks
  initial begin : monitor
    logic p_scl, p_req, p_done;
    int lo_cnt, hi_cnt, off_cnt, on_cnt, gap, npoll;
    bit hi_valid, in_off, on_valid;
    p_scl = 1'b1; p_req = 1'b0; p_done = 1'b0;
    lo_cnt = 0; hi_cnt = 0; off_cnt = 0; on_cnt = 0; gap = 0; npoll = 0;
    hi_valid = 1'b0; in_off = 1'b0; on_valid = 1'b0;
    forever begin
      @(negedge clk);
      if (rst) begin
        p_scl = scl_rel_o; p_req = poll_req_o; p_done = done_o;
      end else begin
        // clock line
        if (p_scl && !scl_rel_o) begin
          sb_pop(EV_FALL, "R2 clock fall");
          if (hi_valid) chk(hi_cnt == HALF, "R3 high phase ticks", hi_cnt, HALF);
          if (on_valid) chk(on_cnt == ONMS || on_cnt == ONMS + 1,
                            "R4 power-up wait ticks", on_cnt, ONMS);
          on_valid = 1'b0;
          hi_valid = 1'b0;
          npoll = 0;
          lo_cnt = us_tick_i ? 1 : 0;
        end else if (!p_scl && scl_rel_o) begin
          sb_pop(EV_RISE, "R2 clock rise");
          chk(lo_cnt == HALF, "R3 low phase ticks", lo_cnt, HALF);
          hi_valid = 1'b1;
          hi_cnt = us_tick_i ? 1 : 0;
        end else if (!scl_rel_o) begin
          lo_cnt += us_tick_i ? 1 : 0;
        end else begin
          hi_cnt += us_tick_i ? 1 : 0;
        end
        chk(sda_rel_o == 1'b1, "R2 data released", sda_rel_o, 1);
        // power
        if (pwr_down_o) begin
          sb_pop(EV_DOWN, "R7 power down");
          in_off = 1'b1;
          off_cnt = ms_tick_i ? 1 : 0;
          hi_valid = 1'b0;
        end else if (pwr_up_o) begin
          sb_pop(EV_UP, "R4 power up");
          if (in_off) chk(off_cnt == OFFMS, "R7 power-off wait ticks", off_cnt, OFFMS);
          in_off = 1'b0;
          on_valid = 1'b1;
          on_cnt = ms_tick_i ? 1 : 0;
          hi_valid = 1'b0;
        end else begin
          if (in_off) off_cnt += ms_tick_i ? 1 : 0;
          if (on_valid) on_cnt += ms_tick_i ? 1 : 0;
        end
        // polls
        if (!p_req && poll_req_o) begin
          sb_pop(EV_POLL, "R5 R6 poll");
          if (npoll > 0) chk(gap == 1, "R5 poll spacing ticks", gap, 1);
          npoll++;
          gap = 0;
          hi_valid = 1'b0;
        end else if (!poll_req_o) begin
          gap += ms_tick_i ? 1 : 0;
        end
        // completion
        if (done_o) begin
          chk(!p_done, "R8 done one cycle", 1, 0);
          sb_pop(reinit_o ? EV_DONE1 : EV_DONE0, "R8 done and reinit");
          done_cnt++;
          hi_valid = 1'b0;
        end
        p_scl = scl_rel_o; p_req = poll_req_o; p_done = done_o;
      end
    end
  end

  // Watchdog
  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic push_burst();
    for (int i = 0; i < PULSES; i++) begin
      exp_q.push_back(EV_FALL);
      exp_q.push_back(EV_RISE);
    end
  endtask

  // Driver: pushes the expected event stream, then starts the sequence
  task automatic run_case(input bit off, input int nfail, input int poke_dly);
    int rem, d0;
    bit ri;
    fail_left = nfail;
    if (off) exp_q.push_back(EV_UP);
    push_burst();
    rem = nfail;
    while (rem >= POLLMAX) begin
      for (int i = 0; i < POLLMAX; i++) exp_q.push_back(EV_POLL);
      exp_q.push_back(EV_DOWN);
      exp_q.push_back(EV_UP);
      push_burst();
      rem -= POLLMAX;
    end
    for (int i = 0; i <= rem; i++) exp_q.push_back(EV_POLL);
    ri = off || (nfail >= POLLMAX);
    exp_q.push_back(ri ? EV_DONE1 : EV_DONE0);
    d0 = done_cnt;
    @(posedge clk); #1;
    start_i = 1'b1; was_off_i = off;
    @(posedge clk); #1;
    start_i = 1'b0; was_off_i = 1'b0;
    @(negedge clk);
    chk(reinit_o == 1'b0, "R8 reinit cleared by start", reinit_o, 0);
    if (poke_dly > 0) begin
      repeat (poke_dly) @(posedge clk);
      #1;
      start_i = 1'b1; was_off_i = 1'b1;
      @(posedge clk); #1;
      start_i = 1'b0; was_off_i = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R5 expected events all seen", exp_q.size(), 0);
    if (poke_dly > 0)
      chk(done_cnt == d0 + 1 && exp_q.size() == 0, "R9 busy start ignored",
          done_cnt - d0, 1);
    chk(reinit_o == ri, "R8 reinit held after done", reinit_o, ri);
    chk(scl_rel_o == 1'b1 && poll_req_o == 1'b0, "R2 lines idle after done",
        scl_rel_o, 1);
  endtask

  initial begin : main
    rst = 1'b1;
    start_i = 1'b0;
    was_off_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(scl_rel_o && sda_rel_o, "R1 lines released in reset", scl_rel_o, 1);
    chk(!pwr_up_o && !pwr_down_o && !poll_req_o && !done_o && !reinit_o,
        "R1 outputs low in reset", done_o, 0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    chk(scl_rel_o && sda_rel_o && !poll_req_o && !done_o && !reinit_o,
        "R1 idle after reset", poll_req_o, 0);

    run_case(1'b0, 0, 0);     // plain recovery, first poll passes (R2 R3 R5)
    run_case(1'b1, 3, 0);     // powered down, three bad identities (R4 R6 R8)
    run_case(1'b0, 0, 40);    // start during burst ignored (R9)
    run_case(1'b0, 2, 800);   // start during polling ignored (R9)
    run_case(1'b0, 49, 0);    // last poll of budget passes, no power cycle (R5)
    run_case(1'b0, 50, 0);    // budget runs out, power cycle and retry (R7)
    run_case(1'b0, 0, 0);     // reinit cleared after a power-cycled run (R8)

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule